// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block generates the two interrupt flags of a two-port shared memory whose address space ends in two reserved mailbox words. The topmost word is the right port's mailbox and the word just below it is the left port's mailbox. When one port writes into the other port's mailbox, the flag of the receiving port goes active (low). The receiving port clears its flag by reading its own mailbox.

The mailbox words stay ordinary storage for a user message. The storage array is outside this block. Only the flag state is built here. Every port input is sampled on the clock. A flag changes one cycle after the qualifying access is seen. A low busy input on a port stops that port's accesses from changing any flag. A synchronous reset puts both flags in a known inactive state, so software does not have to initialise them.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst` is high at a clock edge, both flags are loaded high (inactive), whatever the other inputs are. After reset is released, both flags read high until an access changes them.
- R2: A right-port write to address 0xFFE drives `lt_irq_n` low one cycle later. A write means `rt_cs_n`=0 and `rt_wr_n`=0 with `rt_busy_n`=1.
- R3: A left-port write to address 0xFFF drives `rt_irq_n` low one cycle later. A write means `lt_cs_n`=0 and `lt_wr_n`=0 with `lt_busy_n`=1.
- R4: A left-port access to 0xFFE with `lt_cs_n`=0, `lt_oe_n`=0 and `lt_busy_n`=1 returns `lt_irq_n` high one cycle later. The level of `lt_wr_n` does not matter.
- R5: A right-port access to 0xFFF with `rt_cs_n`=0, `rt_oe_n`=0 and `rt_busy_n`=1 returns `rt_irq_n` high one cycle later. The level of `rt_wr_n` does not matter.
- R6: While a port's busy input is low, that port's accesses neither set nor clear any flag.
- R7: If a flag is set and cleared in the same cycle, the set wins and the flag goes or stays low.
- R8: The following accesses leave both flags unchanged:
  - accesses to other addresses;
  - accesses with chip enable high;
  - a write to a mailbox with output enable high, which does not count as a clear;
  - a read of the opposite port's mailbox.
- R9: A port writing its own mailbox does not set its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_cs_n | input | 1 | Left chip enable, active low |
| lt_wr_n | input | 1 | Left read/write, low = write |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_addr | input | ADDR_W | Left word address |
| lt_busy_n | input | 1 | Left busy, low blocks left's flag actions |
| rt_cs_n | input | 1 | Right chip enable, active low |
| rt_wr_n | input | 1 | Right read/write, low = write |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | ADDR_W | Right word address |
| rt_busy_n | input | 1 | Right busy, low blocks right's flag actions |
| lt_irq_n | output | 1 | Left interrupt flag, active low |
| rt_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The hardest case to reach is a set and a clear of the same flag in the same cycle. This needs one port writing the other's mailbox while the owner reads it at the same edge. The stimulus table drives that alignment explicitly, once for each flag. Busy-blocked accesses are placed while a flag is already low, and again while it is high, so that a wrongly accepted clear or set shows up as a flag change. A write with output enable low into the writer's own mailbox is also applied. It must act as a clear and never as a set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DEF_ADDR_W = 12;

    typedef enum logic [0:0] {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // post: this side wrote the peer mailbox; take: this side read its own mailbox
    typedef struct packed {
        logic post;
        logic take;
    } mbx_evt_t;

    // Mailbox of the right side is the top word, left side's sits one below.
    function automatic logic [31:0] box_addr(input int aw, input side_e s);
        logic [31:0] top;
        top = (32'd1 << aw) - 32'd1;
        return (s == SIDE_R) ? top : top - 32'd1;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int          ADDR_W   = DEF_ADDR_W,
    parameter logic [31:0] OWN_BOX  = 32'hFFE,
    parameter logic [31:0] PEER_BOX = 32'hFFF
) (
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output mbx_evt_t          evt
);
    localparam logic [ADDR_W-1:0] OWN_A  = OWN_BOX[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PEER_A = PEER_BOX[ADDR_W-1:0];

    logic live;

    always_comb begin
        live     = !cs_n && busy_n;
        evt.post = live && !wr_n && (addr == PEER_A);
        evt.take = live && !oe_n && (addr == OWN_A);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)        irq_n <= 1'b1;
        else if (set_i) irq_n <= 1'b0;
        else if (clr_i) irq_n <= 1'b1;
    end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_cs_n,
    input  logic              lt_wr_n,
    input  logic              lt_oe_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_busy_n,
    input  logic              rt_cs_n,
    input  logic              rt_wr_n,
    input  logic              rt_oe_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy_n,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0]  cs_n_a, wr_n_a, oe_n_a, busy_n_a, irq_n_a;
    logic [ADDR_W-1:0] addr_a [NSIDE];
    mbx_evt_t          evt_a  [NSIDE];

    assign cs_n_a   = {rt_cs_n,   lt_cs_n};
    assign wr_n_a   = {rt_wr_n,   lt_wr_n};
    assign oe_n_a   = {rt_oe_n,   lt_oe_n};
    assign busy_n_a = {rt_busy_n, lt_busy_n};
    assign addr_a[SIDE_L] = lt_addr;
    assign addr_a[SIDE_R] = rt_addr;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam side_e ME   = side_e'(s);
        localparam side_e PEER = side_e'(NSIDE - 1 - s);

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (box_addr(ADDR_W, ME)),
            .PEER_BOX (box_addr(ADDR_W, PEER))
        ) u_dec (
            .cs_n   (cs_n_a[s]),
            .wr_n   (wr_n_a[s]),
            .oe_n   (oe_n_a[s]),
            .busy_n (busy_n_a[s]),
            .addr   (addr_a[s]),
            .evt    (evt_a[s])
        );

        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_a[NSIDE-1-s].post),
            .clr_i (evt_a[s].take),
            .irq_n (irq_n_a[s])
        );
    end

    assign lt_irq_n = irq_n_a[SIDE_L];
    assign rt_irq_n = irq_n_a[SIDE_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk
    import mbx_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              lt_cs_n,
    input logic              lt_wr_n,
    input logic              lt_oe_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_busy_n,
    input logic              rt_cs_n,
    input logic              rt_wr_n,
    input logic              rt_oe_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_busy_n,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);
    localparam logic [31:0] BL = box_addr(ADDR_W, SIDE_L);
    localparam logic [31:0] BR = box_addr(ADDR_W, SIDE_R);

    logic l_set, l_clr, r_set, r_clr;
    assign l_set = !rt_cs_n && !rt_wr_n && rt_busy_n && (rt_addr == BL[ADDR_W-1:0]);
    assign l_clr = !lt_cs_n && !lt_oe_n && lt_busy_n && (lt_addr == BL[ADDR_W-1:0]);
    assign r_set = !lt_cs_n && !lt_wr_n && lt_busy_n && (lt_addr == BR[ADDR_W-1:0]);
    assign r_clr = !rt_cs_n && !rt_oe_n && rt_busy_n && (rt_addr == BR[ADDR_W-1:0]);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lt_irq_n && rt_irq_n));
    a_r2_left_set: assert property (@(posedge clk) disable iff (rst)
        l_set |=> !lt_irq_n);
    a_r3_right_set: assert property (@(posedge clk) disable iff (rst)
        r_set |=> !rt_irq_n);
    a_r4_left_clear: assert property (@(posedge clk) disable iff (rst)
        (l_clr && !l_set) |=> lt_irq_n);
    a_r5_right_clear: assert property (@(posedge clk) disable iff (rst)
        (r_clr && !r_set) |=> rt_irq_n);
    a_r6_both_busy: assert property (@(posedge clk) disable iff (rst)
        (!lt_busy_n && !rt_busy_n) |=> ($stable(lt_irq_n) && $stable(rt_irq_n)));
    a_r7_left_set_wins: assert property (@(posedge clk) disable iff (rst)
        (l_set && l_clr) |=> !lt_irq_n);
    a_r7_right_set_wins: assert property (@(posedge clk) disable iff (rst)
        (r_set && r_clr) |=> !rt_irq_n);
    a_r8_left_hold: assert property (@(posedge clk) disable iff (rst)
        (!l_set && !l_clr) |=> $stable(lt_irq_n));
    a_r8_right_hold: assert property (@(posedge clk) disable iff (rst)
        (!r_set && !r_clr) |=> $stable(rt_irq_n));
endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_mbx_irq_top.sv
module tb_mbx_irq_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int NV = 21;

    // Port control nibble {cs_n, wr_n, oe_n, busy_n} followed by a 12-bit address.
    // Vector: {left[15:0], right[15:0], exp_lt, exp_rt, req[3:0]}
    localparam logic [37:0] VEC [NV] = '{
        {16'hF000, 16'hF000, 1'b1, 1'b1, 4'd8},  // idle                          R8
        {16'hF000, 16'h3FFE, 1'b0, 1'b1, 4'd2},  // right writes FFE              R2
        {16'hF000, 16'hF000, 1'b0, 1'b1, 4'd8},  // flag holds                    R8
        {16'h5FFD, 16'hF000, 1'b0, 1'b1, 4'd8},  // read wrong address            R8
        {16'hDFFE, 16'hF000, 1'b0, 1'b1, 4'd8},  // chip enable high              R8
        {16'h4FFE, 16'hF000, 1'b0, 1'b1, 4'd6},  // clear with busy low           R6
        {16'h5FFE, 16'hF000, 1'b1, 1'b1, 4'd4},  // left reads FFE                R4
        {16'h3FFF, 16'hF000, 1'b1, 1'b0, 4'd3},  // left writes FFF               R3
        {16'hF000, 16'h3FFF, 1'b1, 1'b0, 4'd8},  // own write, oe high: no clear  R8
        {16'hF000, 16'h1FFF, 1'b1, 1'b1, 4'd5},  // clear with wr low, oe low     R5
        {16'hF000, 16'h2FFE, 1'b1, 1'b1, 4'd6},  // set with busy low             R6
        {16'h3FFE, 16'hF000, 1'b1, 1'b1, 4'd9},  // left writes own box           R9
        {16'h2FFF, 16'hF000, 1'b1, 1'b1, 4'd6},  // set with busy low             R6
        {16'h3FFF, 16'h5FFF, 1'b1, 1'b0, 4'd7},  // set and clear together        R7
        {16'hF000, 16'h5FFF, 1'b1, 1'b1, 4'd5},  // right reads FFF               R5
        {16'h5FFE, 16'h3FFE, 1'b0, 1'b1, 4'd7},  // set and clear together        R7
        {16'h3FFF, 16'h3FFE, 1'b0, 1'b0, 4'd3},  // both post at once             R3
        {16'h5FFF, 16'h5FFE, 1'b0, 1'b0, 4'd8},  // reads of peer boxes           R8
        {16'hF000, 16'h3FFF, 1'b0, 1'b0, 4'd9},  // right writes own box          R9
        {16'h1FFE, 16'hF000, 1'b1, 1'b0, 4'd4},  // clear with wr low             R4
        {16'hF000, 16'h5FFF, 1'b1, 1'b1, 4'd5}   // right reads FFF               R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lt_cs_n, lt_wr_n, lt_oe_n, lt_busy_n;
    logic rt_cs_n, rt_wr_n, rt_oe_n, rt_busy_n;
    logic [AW-1:0] lt_addr, rt_addr;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .lt_cs_n(lt_cs_n), .lt_wr_n(lt_wr_n), .lt_oe_n(lt_oe_n),
        .lt_addr(lt_addr), .lt_busy_n(lt_busy_n),
        .rt_cs_n(rt_cs_n), .rt_wr_n(rt_wr_n), .rt_oe_n(rt_oe_n),
        .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    task automatic drive(input logic [15:0] l, input logic [15:0] r);
        {lt_cs_n, lt_wr_n, lt_oe_n, lt_busy_n, lt_addr} = l;
        {rt_cs_n, rt_wr_n, rt_oe_n, rt_busy_n, rt_addr} = r;
    endtask

    task automatic check(input string req, input logic el, input logic er);
        checks++;
        if (lt_irq_n !== el || rt_irq_n !== er) begin
            errors++;
            $display("FAIL %s: lt_irq_n/rt_irq_n got %b%b expected %b%b",
                     req, lt_irq_n, rt_irq_n, el, er);
        end
    endtask

    initial begin
        drive(16'hF000, 16'hF000);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flags after reset", 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][37:22], VEC[i][21:6]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][5], VEC[i][4]);
        end

        // R1: reset overrides a pending set on both flags
        drive(16'h3FFF, 16'h3FFE);
        @(negedge clk);
        check("R2 R3 both set before reset", 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset beats set", 1'b1, 1'b1);
        rst = 1'b0;
        drive(16'hF000, 16'hF000);
        @(negedge clk);
        check("R1 idle after reset", 1'b1, 1'b1);

        // R6: busy low on both sides during a full set/clear pattern
        drive(16'h2FFF, 16'h2FFE);
        @(negedge clk);
        check("R6 both busy, no set", 1'b1, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule